// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a processor pipeline and the write port of a level-one data cache. It holds the core's stores in program order. Each store gets a slot when it issues, before its address or data is known. The address and the data arrive later, each through its own port, and each names the slot by its tag. The retire port marks the oldest unretired store as retired. Only a retired store at the oldest position may leave, and it leaves through a ready/valid commit port toward the cache. Writes therefore reach memory in program order.

A load lookup port searches the buffered stores. It searches for the same word address with overlapping bytes. If the youngest overlapping store covers every byte the load wants and its data is present, that store's data is forwarded. Otherwise the load stalls. A load that overlaps nothing goes on to the cache, so it may complete before older stores become visible. That store-then-load reordering is the only reordering the block permits.

A full-fence input holds off allocation and loads until the buffer is empty. A flush input throws away every store that has not retired and keeps the retired ones so they still commit. The depth must be a power of two. Addresses are word addresses, and each store or load carries a byte mask. Every load lookup treats all stores currently held as older than itself.

Top module: `stbuf_top`

## Requirements
- R1: Allocation hands out tags in program order. The first tag after reset is 0, and each accepted allocation returns the next index modulo DEPTH. A new slot has neither address nor data.
- R2: An address write or data write fills only the slot named by its tag. It never reserves a slot, and it never changes how many slots are held.
- R3: A store is offered on the commit port only when it is the oldest held store, has been retired, and holds both address and data. Stores leave in allocation order, one per cycle in which cm_valid and cm_ready are both high.
- R4: With DEPTH slots held, alloc_stall is high and a requested allocation is refused. A refused request takes no tag. The held count never exceeds DEPTH. The pointers carry a wrap bit, so full and empty are told apart.
- R5: A load whose word address matches no held store, or whose byte mask overlaps none, reports neither hit nor stall.
- R6: A load is forwarded (ld_hit high, ld_data equal to that store's data) when the youngest held store with the same word address and an overlapping mask has its data and covers every byte of the load mask.
- R7: A load stalls while any held store still lacks its address. It also stalls when the youngest overlapping store lacks its data.
- R8: A load stalls when the youngest overlapping store does not cover every byte of the load mask. Once that store has committed, the same load no longer stalls.
- R9: While fence_valid is high and the buffer holds any store, alloc_stall is high, every load stalls, and fence_done is low. fence_done goes high once the buffer is empty.
- R10: A flush removes every unretired store, so the next allocated tag is the slot after the last retired store. Stores already retired still commit.
- R11: After reset the buffer is empty, cm_valid is low, alloc_stall is low and no load stalls. A retire request while no unretired store is held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot for an issuing store |
| alloc_stall | output | 1 | Allocation refused this cycle (full or fence) |
| alloc_tag | output | $clog2(DEPTH) | Tag the next accepted allocation receives |
| aw_valid | input | 1 | Address write strobe |
| aw_tag | input | $clog2(DEPTH) | Slot receiving the address |
| aw_addr | input | AW | Store word address |
| aw_mask | input | DW/8 | Store byte mask |
| dw_valid | input | 1 | Data write strobe |
| dw_tag | input | $clog2(DEPTH) | Slot receiving the data |
| dw_data | input | DW | Store data |
| retire_valid | input | 1 | Retire the oldest unretired store |
| flush | input | 1 | Discard all unretired stores |
| cm_valid | output | 1 | Oldest store ready to write the cache |
| cm_ready | input | 1 | Cache accepts the offered store |
| cm_addr | output | AW | Committed word address |
| cm_mask | output | DW/8 | Committed byte mask |
| cm_data | output | DW | Committed data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte mask |
| ld_hit | output | 1 | Load is served by forwarding |
| ld_stall | output | 1 | Load must wait |
| ld_data | output | DW | Forwarded data |
| fence_valid | input | 1 | Full fence pending |
| fence_done | output | 1 | Fence pending and buffer empty |

## Verification
On every cycle, the assertions check pointer invariants. The held count stays within the depth. The retired region stays inside the held region. A flush leaves nothing unretired. A pending fence blocks both allocation and loads while stores remain, and a forwarded load is never also a stall. Commit order, tag sequence, youngest-match selection, partial-overlap stalls and the survival of retired stores across a flush can only be shown by the bench's scenarios. The bench compares the commit stream with its own program-order list and compares load results with values it tracks itself.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef enum logic [1:0] {
    FWD_MISS  = 2'd0,
    FWD_HIT   = 2'd1,
    FWD_STALL = 2'd2
  } fwd_res_e;
endpackage

// File: rtl/stbuf_ptrs.sv
module stbuf_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          fence_block,
  input  logic          retire_req,
  input  logic          head_filled,
  input  logic          cm_ready,
  input  logic          flush,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic [PW-1:0] held_cnt,
  output logic          full,
  output logic          empty,
  output logic          alloc_fire,
  output logic          cm_valid,
  output logic          commit_fire
);
  logic [PW-1:0] head_ptr, tail_ptr, ret_ptr, ret_nxt;
  logic          head_retired, retire_fire;

  function automatic logic [PW-1:0] ptr_dist(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return PW'(a - b);
  endfunction

  function automatic logic is_full(input logic [PW-1:0] t, input logic [PW-1:0] h);
    return (t[IW-1:0] == h[IW-1:0]) && (t[IW] != h[IW]);
  endfunction

  assign head_idx     = head_ptr[IW-1:0];
  assign tail_idx     = tail_ptr[IW-1:0];
  assign held_cnt     = ptr_dist(tail_ptr, head_ptr);
  assign full         = is_full(tail_ptr, head_ptr);
  assign empty        = (tail_ptr == head_ptr);
  assign alloc_fire   = alloc_req && !full && !fence_block && !flush;
  assign retire_fire  = retire_req && (ret_ptr != tail_ptr);
  assign head_retired = (ret_ptr != head_ptr);
  assign cm_valid     = head_retired && head_filled;
  assign commit_fire  = cm_valid && cm_ready;
  assign ret_nxt      = ret_ptr + PW'(retire_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      ret_ptr  <= '0;
    end else begin
      head_ptr <= head_ptr + PW'(commit_fire);
      ret_ptr  <= ret_nxt;
      if (flush) tail_ptr <= ret_nxt;
      else       tail_ptr <= tail_ptr + PW'(alloc_fire);
    end
  end

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    held_cnt <= PW'(DEPTH));

  a_r3_retired_inside_held: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_dist(ret_ptr, head_ptr) <= ptr_dist(tail_ptr, head_ptr));

  a_r10_flush_clears_unretired: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail_ptr == ret_ptr));
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1,
  localparam int MW = DW / 8
) (
  input  logic [IW-1:0]            head_idx,
  input  logic [PW-1:0]            held_cnt,
  input  logic [DEPTH-1:0]         a_vld,
  input  logic [DEPTH-1:0]         d_vld,
  input  logic [DEPTH-1:0][AW-1:0] e_addr,
  input  logic [DEPTH-1:0][MW-1:0] e_mask,
  input  logic [DEPTH-1:0][DW-1:0] e_data,
  input  logic [AW-1:0]            ld_addr,
  input  logic [MW-1:0]            ld_mask,
  output fwd_res_e                 res,
  output logic [DW-1:0]            fwd_data
);
  logic          unknown_addr, found;
  logic [IW-1:0] sel;

  function automatic logic covers(input logic [MW-1:0] have, input logic [MW-1:0] need);
    return (need & ~have) == '0;
  endfunction

  function automatic logic overlaps(input logic [AW-1:0] sa, input logic [MW-1:0] sm,
                                    input logic [AW-1:0] la, input logic [MW-1:0] lm);
    return (sa == la) && ((sm & lm) != '0);
  endfunction

  always_comb begin
    unknown_addr = 1'b0;
    found        = 1'b0;
    sel          = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] idx;
      idx = head_idx + IW'(k);
      if (PW'(k) < held_cnt) begin
        if (!a_vld[idx]) begin
          unknown_addr = 1'b1;
        end else if (overlaps(e_addr[idx], e_mask[idx], ld_addr, ld_mask)) begin
          found = 1'b1;
          sel   = idx;
        end
      end
    end
    if (unknown_addr)
      res = FWD_STALL;
    else if (found && (!d_vld[sel] || !covers(e_mask[sel], ld_mask)))
      res = FWD_STALL;
    else if (found)
      res = FWD_HIT;
    else
      res = FWD_MISS;
    fwd_data = (res == FWD_HIT) ? e_data[sel] : '0;
  end
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1,
  localparam int MW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_stall,
  output logic [IW-1:0] alloc_tag,
  input  logic          aw_valid,
  input  logic [IW-1:0] aw_tag,
  input  logic [AW-1:0] aw_addr,
  input  logic [MW-1:0] aw_mask,
  input  logic          dw_valid,
  input  logic [IW-1:0] dw_tag,
  input  logic [DW-1:0] dw_data,
  input  logic          retire_valid,
  input  logic          flush,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [AW-1:0] cm_addr,
  output logic [MW-1:0] cm_mask,
  output logic [DW-1:0] cm_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [MW-1:0] ld_mask,
  output logic          ld_hit,
  output logic          ld_stall,
  output logic [DW-1:0] ld_data,
  input  logic          fence_valid,
  output logic          fence_done
);
  logic [DEPTH-1:0]         a_vld, d_vld;
  logic [DEPTH-1:0][AW-1:0] e_addr;
  logic [DEPTH-1:0][MW-1:0] e_mask;
  logic [DEPTH-1:0][DW-1:0] e_data;
  logic [IW-1:0]            head_idx, tail_idx;
  logic [PW-1:0]            held_cnt;
  logic                     full, empty, alloc_fire, commit_fire, fence_block;
  fwd_res_e                 fres;
  logic [DW-1:0]            fdata;

  assign fence_block = fence_valid && !empty;
  assign fence_done  = fence_valid && empty;

  stbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_valid),
    .fence_block (fence_block),
    .retire_req  (retire_valid),
    .head_filled (a_vld[head_idx] && d_vld[head_idx]),
    .cm_ready    (cm_ready),
    .flush       (flush),
    .head_idx    (head_idx),
    .tail_idx    (tail_idx),
    .held_cnt    (held_cnt),
    .full        (full),
    .empty       (empty),
    .alloc_fire  (alloc_fire),
    .cm_valid    (cm_valid),
    .commit_fire (commit_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld <= '0;
      d_vld <= '0;
    end else begin
      if (alloc_fire) begin
        a_vld[tail_idx] <= 1'b0;
        d_vld[tail_idx] <= 1'b0;
      end
      if (aw_valid) a_vld[aw_tag] <= 1'b1;
      if (dw_valid) d_vld[dw_tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (aw_valid) begin
      e_addr[aw_tag] <= aw_addr;
      e_mask[aw_tag] <= aw_mask;
    end
    if (dw_valid) e_data[dw_tag] <= dw_data;
  end

  stbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .head_idx (head_idx),
    .held_cnt (held_cnt),
    .a_vld    (a_vld),
    .d_vld    (d_vld),
    .e_addr   (e_addr),
    .e_mask   (e_mask),
    .e_data   (e_data),
    .ld_addr  (ld_addr),
    .ld_mask  (ld_mask),
    .res      (fres),
    .fwd_data (fdata)
  );

  assign alloc_stall = full || fence_block;
  assign alloc_tag   = tail_idx;
  assign cm_addr     = e_addr[head_idx];
  assign cm_mask     = e_mask[head_idx];
  assign cm_data     = e_data[head_idx];
  assign ld_stall    = ld_valid && (fence_block || fres == FWD_STALL);
  assign ld_hit      = ld_valid && !fence_block && fres == FWD_HIT;
  assign ld_data     = fdata;

  a_r9_fence_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && !empty) |-> (alloc_stall && !fence_done && (!ld_valid || ld_stall)));

  a_r6_hit_excludes_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !ld_stall);

  a_r3_commit_needs_fields: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (a_vld[head_idx] && d_vld[head_idx] && !empty));
endmodule

// File: tb/stbuf_top_tb.sv
module stbuf_top_tb;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(DEPTH);
  localparam int MW = DW / 8;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, aw_valid = 0, dw_valid = 0, retire_valid = 0, flush = 0;
  logic cm_ready = 0, ld_valid = 0, fence_valid = 0;
  logic [IW-1:0] aw_tag = '0, dw_tag = '0;
  logic [AW-1:0] aw_addr = '0, ld_addr = '0;
  logic [MW-1:0] aw_mask = '0, ld_mask = '0;
  logic [DW-1:0] dw_data = '0;
  logic alloc_stall, cm_valid, ld_hit, ld_stall, fence_done;
  logic [IW-1:0] alloc_tag;
  logic [AW-1:0] cm_addr;
  logic [MW-1:0] cm_mask;
  logic [DW-1:0] cm_data, ld_data;

  always #10 clk = ~clk;

  stbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

  int checks = 0, fails = 0;
  int tag_exp = 0, ret_tag = 0, q_wr = 0, q_rd = 0;
  logic [AW-1:0] sh_addr [DEPTH];
  logic [MW-1:0] sh_mask [DEPTH];
  logic [DW-1:0] sh_data [DEPTH];
  logic [AW-1:0] q_addr [64];
  logic [MW-1:0] q_mask [64];
  logic [DW-1:0] q_data [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(output int tag);
    @(negedge clk);
    alloc_valid = 1;
    #1;
    chk(!alloc_stall, "R1", "alloc accepted", 64'(alloc_stall), 0);
    chk(int'(alloc_tag) == tag_exp, "R1", "alloc tag order", 64'(alloc_tag), 64'(tag_exp));
    tag = int'(alloc_tag);
    tag_exp = (tag_exp + 1) % DEPTH;
    @(posedge clk); #1;
    alloc_valid = 0;
  endtask

  task automatic do_aw(input int tag, input logic [AW-1:0] a, input logic [MW-1:0] m);
    @(negedge clk);
    aw_valid = 1; aw_tag = IW'(tag); aw_addr = a; aw_mask = m;
    sh_addr[tag] = a; sh_mask[tag] = m;
    @(posedge clk); #1;
    aw_valid = 0;
  endtask

  task automatic do_dw(input int tag, input logic [DW-1:0] d);
    @(negedge clk);
    dw_valid = 1; dw_tag = IW'(tag); dw_data = d;
    sh_data[tag] = d;
    @(posedge clk); #1;
    dw_valid = 0;
  endtask

  task automatic store(output int tag, input logic [AW-1:0] a, input logic [MW-1:0] m,
                       input logic [DW-1:0] d);
    do_alloc(tag);
    do_aw(tag, a, m);
    do_dw(tag, d);
  endtask

  task automatic pulse_retire();
    @(negedge clk);
    retire_valid = 1;
    @(posedge clk); #1;
    retire_valid = 0;
  endtask

  task automatic do_retire();
    pulse_retire();
    q_addr[q_wr % 64] = sh_addr[ret_tag];
    q_mask[q_wr % 64] = sh_mask[ret_tag];
    q_data[q_wr % 64] = sh_data[ret_tag];
    q_wr++;
    ret_tag = (ret_tag + 1) % DEPTH;
  endtask

  task automatic load_chk(input string req, input logic [AW-1:0] a, input logic [MW-1:0] m,
                          input bit e_hit, input bit e_stall, input logic [DW-1:0] e_data);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_mask = m;
    #1;
    chk(ld_hit == e_hit, req, "load hit", 64'(ld_hit), 64'(e_hit));
    chk(ld_stall == e_stall, req, "load stall", 64'(ld_stall), 64'(e_stall));
    if (e_hit) chk(ld_data == e_data, req, "forwarded data", 64'(ld_data), 64'(e_data));
    ld_valid = 0;
  endtask

  task automatic drain(input string req, input int n);
    int got = 0;
    for (int cyc = 0; cyc < 40 && got < n; cyc++) begin
      @(negedge clk);
      cm_ready = 1;
      #1;
      if (cm_valid) begin
        chk(cm_addr == q_addr[q_rd % 64] && cm_mask == q_mask[q_rd % 64] &&
            cm_data == q_data[q_rd % 64], req, "commit order/content",
            {cm_addr, cm_data}, {q_addr[q_rd % 64], q_data[q_rd % 64]});
        q_rd++;
        got++;
      end
      @(posedge clk); #1;
    end
    @(negedge clk);
    cm_ready = 0;
    #1;
    chk(got == n, req, "commit count", 64'(got), 64'(n));
    chk(!cm_valid, req, "nothing further to commit", 64'(cm_valid), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!cm_valid, "R11", "cm_valid after reset", 64'(cm_valid), 0);
    chk(!alloc_stall, "R11", "alloc_stall after reset", 64'(alloc_stall), 0);
    chk(alloc_tag == 0, "R11", "first tag", 64'(alloc_tag), 0);
    load_chk("R11", 32'h10, 4'hF, 0, 0, 0);
  endtask

  task automatic t_order();
    int t0, t1, t2;
    do_alloc(t0); do_alloc(t1); do_alloc(t2);
    do_dw(t1, 32'hB1B1_0001);
    do_aw(t2, 32'h30, 4'hF);
    do_aw(t0, 32'h10, 4'hF);
    do_dw(t2, 32'hC2C2_0002);
    do_aw(t1, 32'h20, 4'h3);
    do_dw(t0, 32'hA0A0_0000);
    @(negedge clk); cm_ready = 1; #1;
    chk(!cm_valid, "R3", "no commit before retire", 64'(cm_valid), 0);
    @(posedge clk); #1; cm_ready = 0;
    do_retire(); do_retire(); do_retire();
    drain("R3", 3);
  endtask

  task automatic t_forward();
    int ta, tb, tc;
    store(ta, 32'h10, 4'hF, 32'h1111_1111);
    store(tb, 32'h10, 4'hF, 32'h2222_2222);
    load_chk("R6", 32'h10, 4'hF, 1, 0, 32'h2222_2222);
    load_chk("R6", 32'h10, 4'h1, 1, 0, 32'h2222_2222);
    load_chk("R5", 32'h20, 4'hF, 0, 0, 0);
    load_chk("R5", 32'h14, 4'hF, 0, 0, 0);
    do_alloc(tc);
    load_chk("R7", 32'h20, 4'hF, 0, 1, 0);
    do_aw(tc, 32'h30, 4'hF);
    load_chk("R7", 32'h30, 4'hF, 0, 1, 0);
    load_chk("R2", 32'h10, 4'hF, 1, 0, 32'h2222_2222);
    do_dw(tc, 32'h3333_3333);
    load_chk("R6", 32'h30, 4'hC, 1, 0, 32'h3333_3333);
    do_retire(); do_retire(); do_retire();
    drain("R3", 3);
  endtask

  task automatic t_partial();
    int t;
    store(t, 32'h40, 4'h3, 32'h0000_BEEF);
    load_chk("R8", 32'h40, 4'hF, 0, 1, 0);
    load_chk("R8", 32'h40, 4'h2, 1, 0, 32'h0000_BEEF);
    load_chk("R5", 32'h40, 4'hC, 0, 0, 0);
    do_retire();
    drain("R8", 1);
    load_chk("R8", 32'h40, 4'hF, 0, 0, 0);
  endtask

  task automatic t_full();
    int t, tags[DEPTH];
    for (int i = 0; i < DEPTH; i++) do_alloc(tags[i]);
    #1;
    chk(alloc_stall, "R4", "stall when full", 64'(alloc_stall), 1);
    @(negedge clk); alloc_valid = 1;
    @(posedge clk); #1; alloc_valid = 0;
    for (int i = 0; i < DEPTH; i++) begin
      do_aw(tags[i], 32'h100 + 32'(i), 4'hF);
      do_dw(tags[i], 32'hF000_0000 + 32'(i));
    end
    #1;
    chk(alloc_stall, "R2", "fills keep buffer full", 64'(alloc_stall), 1);
    for (int i = 0; i < DEPTH; i++) do_retire();
    drain("R4", DEPTH);
    store(t, 32'h200, 4'hF, 32'h0F0F_0F0F);
    do_retire();
    drain("R4", 1);
  endtask

  task automatic t_fence();
    int t;
    store(t, 32'h50, 4'hF, 32'h5555_5555);
    @(negedge clk); fence_valid = 1; #1;
    chk(!fence_done, "R9", "fence not done", 64'(fence_done), 0);
    chk(alloc_stall, "R9", "fence blocks alloc", 64'(alloc_stall), 1);
    load_chk("R9", 32'h60, 4'hF, 0, 1, 0);
    do_retire();
    drain("R9", 1);
    #1;
    chk(fence_done, "R9", "fence done when empty", 64'(fence_done), 1);
    chk(!alloc_stall, "R9", "alloc free after fence", 64'(alloc_stall), 0);
    @(negedge clk); fence_valid = 0;
  endtask

  task automatic t_flush();
    int t0, t1, t2, t3;
    store(t0, 32'h70, 4'hF, 32'h7070_7070);
    store(t1, 32'h74, 4'hF, 32'h7474_7474);
    store(t2, 32'h78, 4'hF, 32'h7878_7878);
    do_retire();
    @(negedge clk); flush = 1;
    @(posedge clk); #1; flush = 0;
    tag_exp = ret_tag;
    load_chk("R10", 32'h74, 4'hF, 0, 0, 0);
    drain("R10", 1);
    store(t3, 32'h7C, 4'hF, 32'h7C7C_7C7C);
    chk(t3 == (t0 + 1) % DEPTH, "R10", "tag after flush", 64'(t3), 64'((t0 + 1) % DEPTH));
    do_retire();
    drain("R10", 1);
  endtask

  task automatic t_idle_retire();
    int t;
    pulse_retire();
    store(t, 32'h90, 4'hF, 32'h9090_9090);
    @(negedge clk); cm_ready = 1; #1;
    chk(!cm_valid, "R11", "idle retire ignored", 64'(cm_valid), 0);
    @(posedge clk); #1; cm_ready = 0;
    do_retire();
    drain("R11", 1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_order();
    t_forward();
    t_partial();
    t_full();
    t_fence();
    t_flush();
    t_idle_retire();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule